// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block translates a virtual page number into a physical frame number by searching a hashed page table held in memory. The requested VPN is folded into a bucket index, and the bucket word at that index holds a pointer to the first element of a chain. Each chain element is three consecutive 32-bit words. The walker follows the chain one element at a time and compares VPNs until it finds a match, reaches a null pointer, or exceeds a configured maximum chain length.

A lookup begins with a one-cycle `start` pulse that carries the VPN and the table base address. The walker issues word reads over a valid/ready request channel. It accepts one response per request on a separate response channel, and only one read is outstanding at a time. When the search ends, `done` rises, and the result stays on the outputs until the next accepted `start`. The result is the hit flag, the frame number, the count of elements examined and a loop-abort flag.

Top module: `hpt_walker`

## Requirements
- R1: The first read of a lookup is at byte address `table_base + 4*h`. Here `h` is the low BKT_W bits of the XOR of VPN bits [VPN_W-1:VPN_W/2] with the zero-extended VPN bits [VPN_W/2-1:0]. The word read there is the pointer to the first chain element.
- R2: An element at byte address P holds three words. The VPN is at P, the frame is at P+4 and the next pointer is at P+8. The walker always reads the VPN word first. It then reads only P+4 when the low VPN_W bits of that word equal the requested VPN, and only P+8 otherwise. It issues no other reads.
- R3: On the first matching element in chain order, the lookup ends with `found`=1, `err`=0 and `frame` equal to the low PFN_W bits of that element's frame word. Later elements with the same VPN are not read.
- R4: A zero bucket pointer, or a zero next pointer after a mismatch, ends the lookup with `found`=0, `err`=0 and `frame`=0.
- R5: `visited` reports how many element VPN words were read during the lookup. It is 0 for an empty bucket.
- R6: Sometimes a mismatch leaves a non-zero next pointer after MAX_CHAIN elements have been examined. In that case the lookup ends with `err`=1, `found`=0 and `visited`=MAX_CHAIN, and no further read is issued. A chain of exactly MAX_CHAIN elements that ends in a null pointer reports not-found with `err`=0.
- R7: `done`, `found`, `frame`, `visited` and `err` hold their values from the end of a lookup until the next `start` taken while idle. A `start` while `busy` is high is ignored and leaves the result unchanged.
- R8: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. Valid is low while idle. No new request is raised before the response to the previous one arrives.
- R9: After reset, `busy`, `done`, `found`, `err`, `visited` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a lookup (taken only while idle) |
| vpn | input | VPN_W | Virtual page number to resolve |
| table_base | input | WORD_W | Byte address of bucket array |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | Result valid, held until next start |
| found | output | 1 | Matching element located |
| err | output | 1 | Walk aborted by chain-length guard |
| frame | output | PFN_W | Frame number of the matching element |
| visited | output | CNT_W | Elements examined in this lookup |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | WORD_W | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | WORD_W | Read data word |

## Verification
Lookups are tried against an empty bucket, a single-element chain, and hits at the head, middle and tail of longer chains. They are also tried against misses that end on a null pointer and against a cyclic chain. These cases separate a correct compare-and-skip order from one that reads frames needlessly, and an early exit from a walk that runs to the end. Chains of exactly the maximum length, with and without a hit on the last element, separate the guard's boundary from an off-by-one abort. Further cases use duplicate VPNs in one chain, VPN and frame words with junk upper bits, and a second start pulse during a walk. These check first-match ordering, field masking and start filtering. Memory ready and response latency vary from request to request, so every read address is compared in order with a behavioural walk of the same memory image.

// File: rtl/hpt_pkg.sv
// Shared types for the hashed page table walker.
package hpt_pkg;
    // Control state: waiting for start, presenting a read, awaiting its data.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_st_e;

    // Which word the current read fetches.
    typedef enum logic [1:0] {
        PH_HEAD = 2'd0,
        PH_VPN  = 2'd1,
        PH_FRM  = 2'd2,
        PH_NXT  = 2'd3
    } walk_ph_e;
endpackage

// File: rtl/hpt_hash.sv
// Bucket selection: folds the VPN in half with XOR, keeps BKT_W bits and
// scales by the 4-byte bucket word to form the bucket-head address.
// Assumes BKT_W does not exceed the upper half width of the VPN.
module hpt_hash #(
    parameter int VPN_W  = 20,
    parameter int BKT_W  = 4,
    parameter int WORD_W = 32
) (
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [WORD_W-1:0] base_i,
    output logic [WORD_W-1:0] head_addr_o
);
    localparam int LO_W = VPN_W / 2;
    localparam int HI_W = VPN_W - LO_W;

    logic [HI_W-1:0]  folded;
    logic [BKT_W-1:0] bucket;

    // Fold halves and form the byte address of the bucket word.
    always_comb begin
        folded      = vpn_i[VPN_W-1:LO_W] ^ HI_W'(vpn_i[LO_W-1:0]);
        bucket      = folded[BKT_W-1:0];
        head_addr_o = base_i + WORD_W'({bucket, 2'b00});
    end
endmodule

// File: rtl/hpt_walk_ctrl.sv
// Chain-walk sequencer: latches a lookup, issues one word read at a time,
// decides on each response whether to read the frame, follow the next
// pointer, stop, or abort at the chain-length limit. Holds the result.
// Assumes the memory returns exactly one response per accepted request.
module hpt_walk_ctrl
    import hpt_pkg::*;
#(
    parameter int VPN_W     = 20,
    parameter int PFN_W     = 20,
    parameter int WORD_W    = 32,
    parameter int MAX_CHAIN = 8,
    parameter int CNT_W     = $clog2(MAX_CHAIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [WORD_W-1:0] base_i,
    input  logic [WORD_W-1:0] head_addr_i,
    output logic [VPN_W-1:0]  vpn_q_o,
    output logic [WORD_W-1:0] base_q_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              found_o,
    output logic              err_o,
    output logic [PFN_W-1:0]  frame_o,
    output logic [CNT_W-1:0]  visited_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [WORD_W-1:0] req_addr_o,
    input  logic              rsp_valid_i,
    input  logic [WORD_W-1:0] rsp_data_i
);
    localparam logic [CNT_W-1:0] VIS_LIM = CNT_W'(MAX_CHAIN);

    walk_st_e          st_q;
    walk_ph_e          ph_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] ptr_q;
    logic [CNT_W-1:0]  vis_q;
    logic              done_q, found_q, err_q;
    logic [PFN_W-1:0]  frame_q;

    // Select the address of the word the current phase needs.
    always_comb begin
        unique case (ph_q)
            PH_HEAD: req_addr_o = head_addr_i;
            PH_VPN:  req_addr_o = ptr_q;
            PH_FRM:  req_addr_o = ptr_q + WORD_W'(4);
            default: req_addr_o = ptr_q + WORD_W'(8);
        endcase
    end

    // Sequence reads through the chain and record the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            ph_q    <= PH_HEAD;
            vpn_q   <= '0;
            base_q  <= '0;
            ptr_q   <= '0;
            vis_q   <= '0;
            done_q  <= 1'b0;
            found_q <= 1'b0;
            err_q   <= 1'b0;
            frame_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        vpn_q   <= vpn_i;
                        base_q  <= base_i;
                        ph_q    <= PH_HEAD;
                        vis_q   <= '0;
                        done_q  <= 1'b0;
                        found_q <= 1'b0;
                        err_q   <= 1'b0;
                        frame_q <= '0;
                        st_q    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (req_ready_i) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_valid_i) begin
                        unique case (ph_q)
                            PH_HEAD: begin
                                if (rsp_data_i == '0) begin
                                    done_q <= 1'b1;
                                    st_q   <= ST_IDLE;
                                end else begin
                                    ptr_q <= rsp_data_i;
                                    ph_q  <= PH_VPN;
                                    st_q  <= ST_ISSUE;
                                end
                            end
                            PH_VPN: begin
                                vis_q <= vis_q + 1'b1;
                                ph_q  <= (rsp_data_i[VPN_W-1:0] == vpn_q) ? PH_FRM : PH_NXT;
                                st_q  <= ST_ISSUE;
                            end
                            PH_FRM: begin
                                frame_q <= rsp_data_i[PFN_W-1:0];
                                found_q <= 1'b1;
                                done_q  <= 1'b1;
                                st_q    <= ST_IDLE;
                            end
                            default: begin
                                if (rsp_data_i == '0) begin
                                    done_q <= 1'b1;
                                    st_q   <= ST_IDLE;
                                end else if (vis_q == VIS_LIM) begin
                                    err_q  <= 1'b1;
                                    done_q <= 1'b1;
                                    st_q   <= ST_IDLE;
                                end else begin
                                    ptr_q <= rsp_data_i;
                                    ph_q  <= PH_VPN;
                                    st_q  <= ST_ISSUE;
                                end
                            end
                        endcase
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign vpn_q_o     = vpn_q;
    assign base_q_o    = base_q;
    assign busy_o      = (st_q != ST_IDLE);
    assign done_o      = done_q;
    assign found_o     = found_q;
    assign err_o       = err_q;
    assign frame_o     = frame_q;
    assign visited_o   = vis_q;
    assign req_valid_o = (st_q == ST_ISSUE);
endmodule

// File: rtl/hpt_walker.sv
// Top of the hashed page table walker: joins the bucket hash to the
// chain-walk sequencer. Assumes word-aligned pointers in memory and
// VPN_W, PFN_W no wider than WORD_W.
module hpt_walker #(
    parameter int VPN_W     = 20,
    parameter int PFN_W     = 20,
    parameter int WORD_W    = 32,
    parameter int BKT_W     = 4,
    parameter int MAX_CHAIN = 8,
    localparam int CNT_W    = $clog2(MAX_CHAIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [WORD_W-1:0] table_base,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic              err,
    output logic [PFN_W-1:0]  frame,
    output logic [CNT_W-1:0]  visited,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);
    logic [VPN_W-1:0]  vpn_q;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] head_addr;

    hpt_hash #(.VPN_W(VPN_W), .BKT_W(BKT_W), .WORD_W(WORD_W)) u_hash (
        .vpn_i       (vpn_q),
        .base_i      (base_q),
        .head_addr_o (head_addr)
    );

    hpt_walk_ctrl #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .WORD_W(WORD_W),
        .MAX_CHAIN(MAX_CHAIN), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .vpn_i       (vpn),
        .base_i      (table_base),
        .head_addr_i (head_addr),
        .vpn_q_o     (vpn_q),
        .base_q_o    (base_q),
        .busy_o      (busy),
        .done_o      (done),
        .found_o     (found),
        .err_o       (err),
        .frame_o     (frame),
        .visited_o   (visited),
        .req_valid_o (mem_req_valid),
        .req_ready_i (mem_req_ready),
        .req_addr_o  (mem_req_addr),
        .rsp_valid_i (mem_rsp_valid),
        .rsp_data_i  (mem_rsp_data)
    );
endmodule

// File: rtl/hpt_walker_chk.sv
// Protocol and result checks for hpt_walker, attached by bind.
module hpt_walker_chk #(
    parameter int VPN_W     = 20,
    parameter int PFN_W     = 20,
    parameter int WORD_W    = 32,
    parameter int MAX_CHAIN = 8,
    parameter int CNT_W     = $clog2(MAX_CHAIN + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic              err,
    input logic [PFN_W-1:0]  frame,
    input logic [CNT_W-1:0]  visited,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [WORD_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid
);
    logic outstanding_q;

    // Track whether an accepted read still awaits its data.
    always_ff @(posedge clk) begin
        if (!rst_n)                          outstanding_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outstanding_q <= 1'b1;
        else if (mem_rsp_valid)              outstanding_q <= 1'b0;
    end

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding_q |-> !mem_req_valid);

    assert_busy_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(found) && $stable(err)
                           && $stable(frame) && $stable(visited));

    assert_found_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> done && !err);

    assert_visit_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        visited <= CNT_W'(MAX_CHAIN));
endmodule

bind hpt_walker hpt_walker_chk #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .WORD_W(WORD_W),
    .MAX_CHAIN(MAX_CHAIN), .CNT_W(CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .found         (found),
    .err           (err),
    .frame         (frame),
    .visited       (visited),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/hpt_walker_tb_top.sv
// Bench: behavioural memory with random ready/latency, behavioural chain
// walk producing the expected read sequence and result.
module hpt_walker_tb_top;
    localparam int VPN_W = 20;
    localparam int PFN_W = 20;
    localparam int WORD_W = 32;
    localparam int BKT_W = 4;
    localparam int MAXC = 4;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int unsigned BASE = 32'h1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VPN_W-1:0] vpn = '0;
    logic [WORD_W-1:0] table_base = '0;
    logic busy, done, found, err;
    logic [PFN_W-1:0] frame;
    logic [CNT_W-1:0] visited;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [WORD_W-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [WORD_W-1:0] mem_rsp_data = '0;

    int total = 0;
    int bad = 0;

    logic [31:0] mem [int unsigned];
    int unsigned exp_q [$];
    int unsigned e_found, e_err, e_frame, e_vis;

    always #4 clk = ~clk;

    hpt_walker #(.VPN_W(VPN_W), .PFN_W(PFN_W), .WORD_W(WORD_W),
                 .BKT_W(BKT_W), .MAX_CHAIN(MAXC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vpn(vpn),
        .table_base(table_base), .busy(busy), .done(done), .found(found),
        .err(err), .frame(frame), .visited(visited),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned rd(input int unsigned a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic int unsigned mkvpn(input int unsigned h, input int unsigned salt);
        return ((salt & 10'h3FF) << 10) | (((salt ^ h) & 15) | (salt & 10'h3F0));
    endfunction

    task automatic put_elem(input int unsigned a, input int unsigned v,
                            input int unsigned f, input int unsigned n);
        mem[a] = v; mem[a + 4] = f; mem[a + 8] = n;
    endtask

    // Behavioural walk of the bench memory: expected reads and result.
    task automatic ref_walk(input int unsigned v);
        int unsigned h, ptr, nxt;
        exp_q.delete();
        e_found = 0; e_err = 0; e_frame = 0; e_vis = 0;
        h = ((v >> 10) ^ (v & 10'h3FF)) & ((1 << BKT_W) - 1);
        exp_q.push_back(BASE + h * 4);
        ptr = rd(BASE + h * 4);
        while (ptr != 0) begin
            exp_q.push_back(ptr);
            e_vis++;
            if ((rd(ptr) & ((1 << VPN_W) - 1)) == v) begin
                exp_q.push_back(ptr + 4);
                e_found = 1;
                e_frame = rd(ptr + 4) & ((1 << PFN_W) - 1);
                break;
            end
            exp_q.push_back(ptr + 8);
            nxt = rd(ptr + 8);
            if (nxt == 0) break;
            if (e_vis == MAXC) begin e_err = 1; break; end
            ptr = nxt;
        end
    endtask

    // Memory responder: random ready, 1..3 cycle latency, checks each read address (R1, R2).
    initial begin
        bit pending = 0;
        int dly = 0;
        int unsigned pdata = 0;
        int unsigned a;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (pending) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pdata;
                    pending = 0;
                end else dly--;
            end else if (rst_n && mem_req_valid) begin
                if ($urandom_range(0, 3) != 0) begin
                    mem_req_ready = 1'b1;
                    a = mem_req_addr;
                    if (exp_q.size() == 0) begin
                        chk("R2 unexpected read", a, 0);
                    end else begin
                        chk("R1/R2 read address", a, exp_q.pop_front());
                    end
                    pending = 1;
                    dly = $urandom_range(0, 2);
                    pdata = rd(a);
                end
            end
        end
    end

    task automatic check_result(input string tag);
        chk({tag, " R3 found"}, found, e_found);
        chk({tag, " R3 frame"}, frame, e_frame);
        chk({tag, " R5 visited"}, visited, e_vis);
        chk({tag, " R6 err"}, err, e_err);
        chk({tag, " R2 reads left"}, exp_q.size(), 0);
    endtask

    task automatic lookup(input string tag, input int unsigned v, input bit poke);
        int n;
        ref_walk(v);
        @(negedge clk);
        start = 1'b1; vpn = v[VPN_W-1:0]; table_base = BASE;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R7 busy after start"}, busy, 1);
        if (poke) begin
            @(negedge clk);
            start = 1'b1; vpn = v[VPN_W-1:0] ^ 20'h1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        if (!done) chk({tag, " watchdog"}, 0, 1);
        check_result(tag);
        repeat (3) @(negedge clk);
        chk({tag, " R7 done held"}, done, 1);
        check_result({tag, " held"});
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("global watchdog", 0, 1);
        finish_run();
    end

    initial begin
        // bucket 1: single element, junk above VPN and PFN fields
        put_elem(32'h2000, 32'hF00000 | mkvpn(1, 7), 32'hABC12345, 0);
        mem[BASE + 1 * 4] = 32'h2000;
        // bucket 2: three elements
        put_elem(32'h2100, mkvpn(2, 1), 32'h00011, 32'h2110);
        put_elem(32'h2110, mkvpn(2, 2), 32'h00022, 32'h2120);
        put_elem(32'h2120, mkvpn(2, 3), 32'h00033, 0);
        mem[BASE + 2 * 4] = 32'h2100;
        // bucket 3: exactly MAXC elements
        for (int i = 0; i < MAXC; i++)
            put_elem(32'h2200 + i * 16, mkvpn(3, 20 + i), 32'h300 + i,
                     (i == MAXC - 1) ? 0 : 32'h2200 + (i + 1) * 16);
        mem[BASE + 3 * 4] = 32'h2200;
        // bucket 4: cyclic chain of two
        put_elem(32'h2300, mkvpn(4, 40), 32'h440, 32'h2310);
        put_elem(32'h2310, mkvpn(4, 41), 32'h441, 32'h2300);
        mem[BASE + 4 * 4] = 32'h2300;
        // bucket 5: duplicate VPN
        put_elem(32'h2400, mkvpn(5, 50), 32'h555, 32'h2410);
        put_elem(32'h2410, mkvpn(5, 51), 32'h111, 32'h2420);
        put_elem(32'h2420, mkvpn(5, 51), 32'h222, 0);
        mem[BASE + 5 * 4] = 32'h2400;

        repeat (3) @(negedge clk);
        chk("R9 busy", busy, 0);
        chk("R9 done", done, 0);
        chk("R9 found", found, 0);
        chk("R9 err", err, 0);
        chk("R9 visited", visited, 0);
        chk("R9 req_valid", mem_req_valid, 0);
        rst_n = 1'b1;

        lookup("R4 empty bucket", mkvpn(0, 5), 0);
        lookup("R1 single hit", mkvpn(1, 7), 0);
        lookup("R3 tail hit", mkvpn(2, 3), 0);
        lookup("R3 head hit", mkvpn(2, 1), 0);
        lookup("R4 miss null", mkvpn(2, 9), 0);
        lookup("R6 max-length hit", mkvpn(3, 20 + MAXC - 1), 0);
        lookup("R6 max-length miss", mkvpn(3, 99), 0);
        lookup("R6 cyclic abort", mkvpn(4, 77), 0);
        lookup("R3 cyclic hit", mkvpn(4, 41), 0);
        lookup("R3 first duplicate", mkvpn(5, 51), 0);
        lookup("R7 start while busy", mkvpn(2, 2), 1);
        lookup("R1 hash upper bits", mkvpn(1, 300), 0);
        finish_run();
    end
endmodule